// File: doc/BRIEF.md
# One-Time-Programmable Byte Programming Controller

This block controls byte programming of a one-time-programmable memory array that sits on a simple CPU register bus. A single control register holds two command bits. The latch-enable bit switches the array port from normal reading to programming mode. The pulse bit applies the programming pulse. Two status bits sit beside them: a done flag and a sticky error flag. The array is a behavioural model whose erased value is all zeros.

Software programs a byte in four steps. It sets latch-enable, then writes the target byte with an ordinary array write; the block captures that write's address and data instead of storing them. It then sets the pulse bit and keeps it set until the done flag appears. Finally it clears both bits. The captured byte is ORed into the array when the pulse has been held for `PROG_CYCLES` clock cycles. If the pulse is dropped earlier, nothing is written and the error flag is raised.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset, all four control register bits read 0: latch-enable (bit 0), pulse (bit 1), done (bit 2) and error (bit 3). Bits 7:4 always read 0. Every array location reads 0 before it is programmed.
- R2: While latch-enable is 1, array reads return 0. From the cycle after latch-enable is cleared, reads return the stored contents again.
- R3: While latch-enable is 1, only the first array write captures an address and data; later writes are ignored. Array writes made while latch-enable is 0 never change the array.
- R4: Any register write that leaves latch-enable at 0 also leaves the pulse bit at 0.
- R5: A register write with bits 1:0 equal to 11 while latch-enable is 0 ends with latch-enable at 1 and pulse at 0.
- R6: A register write sets the pulse bit only if latch-enable was already 1 before that write.
- R7: Once the pulse bit is set, done reads 1 after exactly `PROG_CYCLES` clock edges with the pulse held. At that point the captured byte is ORed into the array at the captured address.
- R8: If the pulse bit is cleared before done, the array is left unchanged and the error bit is set. Writing 1 to bit 3 clears the error bit; writing 0 leaves it as it is.
- R9: Programming only sets bits. Programming a location that is already programmed gives the OR of the old and new bytes.
- R10: Clearing latch-enable discards the captured byte. A later pulse with no new capture leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| arr_wr_i | input | 1 | Array write strobe |
| arr_addr_i | input | ADDR_W | Array address for reads and writes |
| arr_wdata_i | input | DATA_W | Array write data |
| arr_rdata_o | output | DATA_W | Array read data (0 while latch-enable is 1) |
| prog_done_o | output | 1 | High while the programming pulse has met its time |

## Verification
A wrong capture state shows up only after the pulse completes and latch-enable is cleared. It appears as a wrong byte on `arr_rdata_o` at the target address or at the address of an ignored write, one cycle after the clearing write. A counter that is off by one appears as done rising one edge early or late, so the bench samples done on both the edge before and the edge of the expected rise. A broken interlock is visible on `reg_rdata_o` in the cycle after the offending write. A missing abort appears as an error bit that stays 0, or as a byte that was stored when it should not have been.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_LATCH = 0;
  localparam int unsigned BIT_PULSE = 1;
  localparam int unsigned BIT_DONE  = 2;
  localparam int unsigned BIT_ERR   = 3;

  typedef struct packed {
    logic err;
    logic done;
    logic pulse;
    logic latch;
  } ctrl_stat_t;

  function automatic logic [REG_W-1:0] pack_stat(input ctrl_stat_t s);
    logic [REG_W-1:0] r;
    r            = '0;
    r[BIT_LATCH] = s.latch;
    r[BIT_PULSE] = s.pulse;
    r[BIT_DONE]  = s.done;
    r[BIT_ERR]   = s.err;
    return r;
  endfunction
endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_prog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             abort_i,
  output logic             latch_o,
  output logic             pulse_o,
  output logic             pulse_nxt_o,
  output logic             err_o
);
  logic latch_q, pulse_q, err_q;
  logic latch_nxt, pulse_nxt, err_nxt;

  always_comb begin
    latch_nxt = latch_q;
    pulse_nxt = pulse_q;
    if (wr_i) begin
      latch_nxt = wdata_i[BIT_LATCH];
      // pulse needs latch already on, and latch kept on by this write
      pulse_nxt = wdata_i[BIT_PULSE] & wdata_i[BIT_LATCH] & latch_q;
    end
  end

  always_comb begin
    err_nxt = err_q;
    if (wr_i && wdata_i[BIT_ERR]) err_nxt = 1'b0;
    if (abort_i)                  err_nxt = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      latch_q <= latch_nxt;
      pulse_q <= pulse_nxt;
      err_q   <= err_nxt;
    end
  end

  assign latch_o     = latch_q;
  assign pulse_o     = pulse_q;
  assign pulse_nxt_o = pulse_nxt;
  assign err_o       = err_q;
endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int unsigned PROG_CYCLES = 20,
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic pulse_nxt_i,
  output logic done_o,
  output logic commit_o,
  output logic abort_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!pulse_i) cnt_q <= '0;
    else if (!at_max)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o   = pulse_i & at_max;
  // commit on the edge the count completes, only if the pulse survives it
  assign commit_o = pulse_i & pulse_nxt_i & (cnt_q == CNT_LAST);
  assign abort_o  = pulse_i & ~pulse_nxt_i & ~at_max;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              cap_valid_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_data_q;
  logic [DATA_W-1:0] mem [DEPTH];

  // erased state of the behavioural model
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_valid_q <= 1'b0;
      cap_addr_q  <= '0;
      cap_data_q  <= '0;
    end else if (!latch_i) begin
      cap_valid_q <= 1'b0;
    end else if (wr_i && !cap_valid_q) begin
      cap_valid_q <= 1'b1;
      cap_addr_q  <= addr_i;
      cap_data_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit_i && cap_valid_q) mem[cap_addr_q] <= mem[cap_addr_q] | cap_data_q;
  end

  assign rdata_o = latch_i ? '0 : mem[addr_i];
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [DATA_W-1:0] arr_wdata_i,
  output logic [DATA_W-1:0] arr_rdata_o,
  output logic              prog_done_o
);
  logic latch, pulse, pulse_nxt, err;
  logic done, commit, abort;
  ctrl_stat_t stat;

  otp_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .abort_i     (abort),
    .latch_o     (latch),
    .pulse_o     (pulse),
    .pulse_nxt_o (pulse_nxt),
    .err_o       (err)
  );

  otp_pulse_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (pulse),
    .pulse_nxt_i (pulse_nxt),
    .done_o      (done),
    .commit_o    (commit),
    .abort_o     (abort)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_i  (latch),
    .wr_i     (arr_wr_i),
    .addr_i   (arr_addr_i),
    .wdata_i  (arr_wdata_i),
    .commit_i (commit),
    .rdata_o  (arr_rdata_o)
  );

  always_comb begin
    stat.latch = latch;
    stat.pulse = pulse;
    stat.done  = done;
    stat.err   = err;
  end

  assign reg_rdata_o = pack_stat(stat);
  assign prog_done_o = done;
endmodule

// File: rtl/otp_prog_checker.sv
module otp_prog_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [7:0]        reg_wdata_i,
  input logic              latch,
  input logic              pulse,
  input logic              err,
  input logic              commit,
  input logic              prog_done_o,
  input logic [DATA_W-1:0] arr_rdata_o
);
  assert_pulse_needs_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch |-> !pulse);

  assert_read_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |-> (arr_rdata_o == '0));

  assert_both_set_interlock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[1:0] == 2'b11 && !latch) |=> (latch && !pulse));

  assert_commit_then_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> prog_done_o);

  assert_err_on_early_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $fell(pulse));
endmodule

bind otp_prog_ctrl otp_prog_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .latch       (latch),
  .pulse       (pulse),
  .err         (err),
  .commit      (commit),
  .prog_done_o (prog_done_o),
  .arr_rdata_o (arr_rdata_o)
);

// File: tb/otp_prog_ctrl_bench.sv
module otp_prog_ctrl_bench;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;
  localparam int unsigned PC = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic [7:0]    reg_wdata_i = '0;
  logic [7:0]    reg_rdata_o;
  logic          arr_wr_i = 1'b0;
  logic [AW-1:0] arr_addr_i = '0;
  logic [DW-1:0] arr_wdata_i = '0;
  logic [DW-1:0] arr_rdata_o;
  logic          prog_done_o;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  otp_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u_otp_prog_ctrl (
    .clk_i, .rst_ni, .reg_wr_i, .reg_wdata_i, .reg_rdata_o,
    .arr_wr_i, .arr_addr_i, .arr_wdata_i, .arr_rdata_o, .prog_done_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic arr_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    arr_wr_i = 1'b1; arr_addr_i = a; arr_wdata_i = d;
    @(negedge clk_i);
    arr_wr_i = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    arr_addr_i = a;
    #1;
    chk(req, int'(arr_rdata_o), int'(exp));
  endtask

  task automatic t_reset;
    chk("R1 status", int'(reg_rdata_o), 0);
    chk("R1 done port", int'(prog_done_o), 0);
    read_chk("R1 erased", 6'd5, 8'h00);
  endtask

  task automatic t_program;
    reg_write(8'h01);
    chk("R2 latch on", int'(reg_rdata_o), 8'h01);
    arr_write(6'd10, 8'h5A);
    read_chk("R2 read blocked", 6'd10, 8'h00);
    reg_write(8'h03);
    chk("R6 pulse set", int'(reg_rdata_o), 8'h03);
    repeat (PC - 1) @(negedge clk_i);
    chk("R7 not yet done", int'(prog_done_o), 0);
    @(negedge clk_i);
    chk("R7 done port", int'(prog_done_o), 1);
    chk("R7 done bit", int'(reg_rdata_o), 8'h07);
    reg_write(8'h00);
    chk("R4 cleared", int'(reg_rdata_o), 8'h00);
    read_chk("R2 read restored R7 stored", 6'd10, 8'h5A);
  endtask

  task automatic t_or;
    reg_write(8'h01);
    arr_write(6'd10, 8'hA1);
    reg_write(8'h03);
    repeat (PC) @(negedge clk_i);
    reg_write(8'h00);
    read_chk("R9 or merge", 6'd10, 8'hFB);
  endtask

  task automatic t_both_set;
    reg_write(8'h03);
    chk("R5 latch only", int'(reg_rdata_o), 8'h01);
    reg_write(8'h00);
    reg_write(8'h02);
    chk("R6 pulse without latch", int'(reg_rdata_o), 8'h00);
    reg_write(8'h01);
    reg_write(8'h03);
    reg_write(8'h02);
    chk("R4 latch drop kills pulse", int'(reg_rdata_o) & 8'h03, 8'h00);
    reg_write(8'h08);
    chk("R8 w1c", int'(reg_rdata_o), 8'h00);
  endtask

  task automatic t_abort;
    reg_write(8'h01);
    arr_write(6'd20, 8'h33);
    reg_write(8'h03);
    repeat (3) @(negedge clk_i);
    reg_write(8'h01);
    chk("R8 err set", int'(reg_rdata_o), 8'h09);
    reg_write(8'h00);
    chk("R8 err sticky w0", int'(reg_rdata_o), 8'h08);
    read_chk("R8 no write", 6'd20, 8'h00);
    reg_write(8'h08);
    chk("R8 err cleared", int'(reg_rdata_o), 8'h00);
  endtask

  task automatic t_capture_first;
    arr_write(6'd40, 8'hFF);
    read_chk("R3 normal write ignored", 6'd40, 8'h00);
    reg_write(8'h01);
    arr_write(6'd30, 8'h0F);
    arr_write(6'd31, 8'hF0);
    reg_write(8'h03);
    repeat (PC) @(negedge clk_i);
    reg_write(8'h00);
    read_chk("R3 first captured", 6'd30, 8'h0F);
    read_chk("R3 second ignored", 6'd31, 8'h00);
  endtask

  task automatic t_fresh;
    reg_write(8'h01);
    reg_write(8'h03);
    repeat (PC) @(negedge clk_i);
    chk("R10 timer runs", int'(prog_done_o), 1);
    reg_write(8'h00);
    read_chk("R10 addr30 same", 6'd30, 8'h0F);
    read_chk("R10 addr31 blank", 6'd31, 8'h00);
    read_chk("R10 addr20 blank", 6'd20, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_program();
    t_or();
    t_both_set();
    t_abort();
    t_capture_first();
    t_fresh();
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule